// File: doc/BRIEF.md
# Prioritised Level Interrupt Status Controller

This block gathers interrupt requests from seven prioritised bus levels and eight special sources into one status picture. It then fans them out onto eight interrupt output lines. The special sources are: bus error, local error, DMA done, system fail, AC fail, software interrupt, software acknowledge and bus ownership.

Every source has three pieces of state:
- a latched status bit;
- an enable bit;
- a 3-bit route that picks the output line it drives.

A level becomes pending when the bus acknowledge for that level completes. The acknowledge is modelled here as a strobe that carries the level number, an 8-bit status/ID and an error flag. The block keeps the ID and the error flag per level. The special sources become pending from single-cycle pulses.

Software works through a small word-addressed register port:
- It reads the status and clears it by writing ones.
- It writes the enables and the two route maps.
- It reads a priority encoder that names the highest pending level.
- It reads the per-level ID records.

Because status is kept while its enable is off, software can mask a level during service. The status bit stays set, which refuses a second acknowledge at that level. The output line drops so that higher levels can still get through.

Top module: `irq_level_collector`

## Requirements
- R1: An acknowledge strobe for level n (1 to 7) is accepted only if the level's enable is set and its status bit is clear in that cycle. Level number 0 is never accepted. On acceptance the level's status bit (register bit n-1) is set, and its ID record is loaded, both at the same clock edge.
- R2: A pulse on special source k (0 to 7) sets status bit 8+k only if enable bit 8+k is set in that cycle. Otherwise the pulse leaves no trace.
- R3: The status register at offset 0x00 is cleared by writing ones. Writing a 0 bit leaves that bit unchanged. When a set and a clear of one bit fall in the same cycle, the set wins. Bit 7 reads 0.
- R4: The enable register at offset 0x04 is read/write, with the same bit layout as status. Clearing an enable leaves the latched status set but removes that source from its output line.
- R5: Output line j is high exactly when some source has both status and enable set and its route equals j. Level routes are at offset 0x08, with level n at bits [3n-1:3n-3]. Special routes are at offset 0x0C, with source k at bits [3k+2:3k].
- R6: The register at offset 0x10 returns in bits [2:0] the highest level whose status bit is set, whatever its enable. It returns 0 when no level is pending.
- R7: The ID record of level n reads at offset 0x20+4(n-1). Bits [7:0] hold the captured ID and bit 8 holds the error flag. While the level's status is set, a new acknowledge at that level is ignored and the record is unchanged.
- R8: After reset, every status, enable, route and ID record is zero and all output lines are low. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid_i | input | 1 | Acknowledge completed this cycle |
| ack_level_i | input | 3 | Level number of the acknowledge (1 to 7) |
| ack_id_i | input | 8 | Status/ID returned by the acknowledge |
| ack_err_i | input | 1 | Acknowledge failed |
| spec_pulse_i | input | 8 | One pulse per special source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 8 | Interrupt output lines |

## Verification
Directed cases walk one level through its whole life. The level is first acknowledged while disabled, then enabled and acknowledged, then acknowledged again while pending, then masked, and finally cleared. These steps separate gating by enable from blocking by status, and masking from clearing. Further directed cases apply a clear and a set to the same bit in one cycle, write all-zero clears, read unmapped offsets, and hold two pending levels with different enables. These show that the priority follows status only and that a set beats a clear. Seeded random traffic then mixes writes, acknowledges and pulses on all sources and compares every line, status, enable, priority and ID record against a bench model each cycle. The random routes make many sources share lines, which exposes faults in the line OR and in the route-field slicing.

// File: rtl/irq_lc_pkg.sv
`timescale 1ns/1ps
package irq_lc_pkg;
    // register byte offsets
    localparam int unsigned OFF_STAT  = 'h00;
    localparam int unsigned OFF_EN    = 'h04;
    localparam int unsigned OFF_LMAP  = 'h08;
    localparam int unsigned OFF_SMAP  = 'h0C;
    localparam int unsigned OFF_PRIO  = 'h10;
    localparam int unsigned OFF_ID    = 'h20;
    localparam int unsigned ID_STRIDE = 4;

    // special source index order
    typedef enum logic [2:0] {
        SP_BUS_ERR  = 3'd0,
        SP_LOC_ERR  = 3'd1,
        SP_DMA_DONE = 3'd2,
        SP_SYS_FAIL = 3'd3,
        SP_AC_FAIL  = 3'd4,
        SP_SW_INT   = 3'd5,
        SP_SW_ACK   = 3'd6,
        SP_BUS_OWN  = 3'd7
    } spec_src_e;
endpackage

// File: rtl/lic_ack_capture.sv
`timescale 1ns/1ps
module lic_ack_capture #(
    parameter int unsigned NUM_LEVELS = 7,
    parameter int unsigned ID_W       = 8,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS + 1),
    localparam int unsigned REC_W     = ID_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ack_valid_i,
    input  logic [LVL_W-1:0]            ack_level_i,
    input  logic [ID_W-1:0]             ack_id_i,
    input  logic                        ack_err_i,
    input  logic [NUM_LEVELS-1:0]       lvl_stat_i,
    input  logic [NUM_LEVELS-1:0]       lvl_en_i,
    output logic [NUM_LEVELS-1:0]       lvl_set_o,
    output logic [NUM_LEVELS*REC_W-1:0] id_flat_o
);
    typedef struct packed {
        logic [NUM_LEVELS-1:0][REC_W-1:0] rec;
    } cap_t;

    cap_t cap_d, cap_q;

    // acceptance: enabled, not already pending, level number matches
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_accept
        assign lvl_set_o[i] = ack_valid_i
                            && (ack_level_i == LVL_W'(i + 1))
                            && lvl_en_i[i]
                            && !lvl_stat_i[i];
    end

    always_comb begin
        cap_d = cap_q;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (lvl_set_o[i]) begin
                cap_d.rec[i] = {ack_err_i, ack_id_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign id_flat_o = cap_q.rec;
endmodule

// File: rtl/lic_prio_enc.sv
`timescale 1ns/1ps
module lic_prio_enc #(
    parameter int unsigned NUM_LEVELS = 7,
    localparam int unsigned LVL_W     = $clog2(NUM_LEVELS + 1)
) (
    input  logic [NUM_LEVELS-1:0] pend_i,
    output logic [LVL_W-1:0]      top_o
);
    // later (higher) levels overwrite earlier ones
    always_comb begin
        top_o = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (pend_i[i]) begin
                top_o = LVL_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/lic_router.sv
`timescale 1ns/1ps
module lic_router #(
    parameter int unsigned NUM_SRC   = 15,
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [NUM_SRC-1:0]        stat_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC*LINE_W-1:0] map_i,
    output logic [NUM_LINES-1:0]      line_o
);
    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (stat_i[s] && en_i[s]
                    && (map_i[s*LINE_W +: LINE_W] == LINE_W'(j))) begin
                    hit = 1'b1;
                end
            end
        end
        assign line_o[j] = hit;
    end
endmodule

// File: rtl/irq_level_collector.sv
`timescale 1ns/1ps
module irq_level_collector
    import irq_lc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS  = 7,
    parameter int unsigned NUM_SPECIAL = 8,
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned ID_W        = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    localparam int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_valid_i,
    input  logic [LVL_W-1:0]       ack_level_i,
    input  logic [ID_W-1:0]        ack_id_i,
    input  logic                   ack_err_i,
    input  logic [NUM_SPECIAL-1:0] spec_pulse_i,
    input  logic                   reg_wr_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [DATA_W-1:0]      reg_wdata_i,
    output logic [DATA_W-1:0]      reg_rdata_o,
    output logic [NUM_LINES-1:0]   irq_o
);
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);
    localparam int unsigned NUM_SRC   = NUM_LEVELS + NUM_SPECIAL;
    localparam int unsigned SPEC_BASE = ((NUM_LEVELS + 7) / 8) * 8;
    localparam int unsigned LMAP_W    = NUM_LEVELS * LINE_W;
    localparam int unsigned SMAP_W    = NUM_SPECIAL * LINE_W;
    localparam int unsigned MAP_W     = LMAP_W + SMAP_W;
    localparam int unsigned REC_W     = ID_W + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] en;
        logic [MAP_W-1:0]   map;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0]          stat_q;
    logic [NUM_SRC-1:0]          en_q;
    logic [MAP_W-1:0]            map_q;
    logic [NUM_LEVELS-1:0]       lvl_set;
    logic [NUM_LEVELS*REC_W-1:0] id_q;
    logic [LVL_W-1:0]            top_lvl;
    logic [NUM_SRC-1:0]          src_w;
    logic [DATA_W-1:0]           stat_word;
    logic [DATA_W-1:0]           en_word;
    logic                        wr_stat, wr_en, wr_lmap, wr_smap;
    logic                        wdata_unused;

    assign stat_q = ctl_q.stat;
    assign en_q   = ctl_q.en;
    assign map_q  = ctl_q.map;

    // register word <-> internal source vector
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl_bits
        assign src_w[i] = reg_wdata_i[i];
    end
    for (genvar k = 0; k < NUM_SPECIAL; k++) begin : g_spc_bits
        assign src_w[NUM_LEVELS + k] = reg_wdata_i[SPEC_BASE + k];
    end

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            stat_word[i] = stat_q[i];
            en_word[i]   = en_q[i];
        end
        for (int k = 0; k < NUM_SPECIAL; k++) begin
            stat_word[SPEC_BASE + k] = stat_q[NUM_LEVELS + k];
            en_word[SPEC_BASE + k]   = en_q[NUM_LEVELS + k];
        end
    end

    assign wdata_unused = ^reg_wdata_i;

    assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_STAT));
    assign wr_en   = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_EN));
    assign wr_lmap = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_LMAP));
    assign wr_smap = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_SMAP));

    lic_ack_capture #(
        .NUM_LEVELS (NUM_LEVELS),
        .ID_W       (ID_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid_i (ack_valid_i),
        .ack_level_i (ack_level_i),
        .ack_id_i    (ack_id_i),
        .ack_err_i   (ack_err_i),
        .lvl_stat_i  (stat_q[NUM_LEVELS-1:0]),
        .lvl_en_i    (en_q[NUM_LEVELS-1:0]),
        .lvl_set_o   (lvl_set),
        .id_flat_o   (id_q)
    );

    lic_prio_enc #(
        .NUM_LEVELS (NUM_LEVELS)
    ) u_enc (
        .pend_i (stat_q[NUM_LEVELS-1:0]),
        .top_o  (top_lvl)
    );

    lic_router #(
        .NUM_SRC   (NUM_SRC),
        .NUM_LINES (NUM_LINES)
    ) u_rt (
        .stat_i (stat_q),
        .en_i   (en_q),
        .map_i  (map_q),
        .line_o (irq_o)
    );

    // next state: set beats clear on the same bit
    always_comb begin
        logic [NUM_SRC-1:0] clr;
        logic [NUM_SRC-1:0] set;
        ctl_d = ctl_q;
        clr   = wr_stat ? src_w : '0;
        set   = {spec_pulse_i & en_q[NUM_SRC-1:NUM_LEVELS], lvl_set};
        ctl_d.stat = (ctl_q.stat & ~clr) | set;
        if (wr_en) begin
            ctl_d.en = src_w;
        end
        if (wr_lmap) begin
            ctl_d.map[LMAP_W-1:0] = reg_wdata_i[LMAP_W-1:0];
        end
        if (wr_smap) begin
            ctl_d.map[MAP_W-1:LMAP_W] = reg_wdata_i[SMAP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(OFF_STAT)) begin
            reg_rdata_o = stat_word;
        end else if (reg_addr_i == ADDR_W'(OFF_EN)) begin
            reg_rdata_o = en_word;
        end else if (reg_addr_i == ADDR_W'(OFF_LMAP)) begin
            reg_rdata_o[LMAP_W-1:0] = map_q[LMAP_W-1:0];
        end else if (reg_addr_i == ADDR_W'(OFF_SMAP)) begin
            reg_rdata_o[SMAP_W-1:0] = map_q[MAP_W-1:LMAP_W];
        end else if (reg_addr_i == ADDR_W'(OFF_PRIO)) begin
            reg_rdata_o[LVL_W-1:0] = top_lvl;
        end else begin
            for (int n = 0; n < NUM_LEVELS; n++) begin
                if (reg_addr_i == ADDR_W'(OFF_ID + ID_STRIDE * n)) begin
                    reg_rdata_o[REC_W-1:0] = id_q[n*REC_W +: REC_W];
                end
            end
        end
    end
endmodule

// File: rtl/irq_lc_chk.sv
`timescale 1ns/1ps
module irq_lc_chk
    import irq_lc_pkg::*;
#(
    parameter int unsigned NUM_LEVELS  = 7,
    parameter int unsigned NUM_SPECIAL = 8,
    parameter int unsigned NUM_LINES   = 8,
    parameter int unsigned ID_W        = 8,
    parameter int unsigned ADDR_W      = 8,
    localparam int unsigned LVL_W      = $clog2(NUM_LEVELS + 1),
    localparam int unsigned NUM_SRC    = NUM_LEVELS + NUM_SPECIAL,
    localparam int unsigned REC_W      = ID_W + 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr_i,
    input logic [ADDR_W-1:0]           reg_addr_i,
    input logic [NUM_SRC-1:0]          stat_q,
    input logic [NUM_SRC-1:0]          en_q,
    input logic [NUM_LEVELS*REC_W-1:0] id_q,
    input logic [NUM_LINES-1:0]        irq_o,
    input logic [LVL_W-1:0]            top_lvl
);
    // R1 R2
    stat_rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    // R3
    stat_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~stat_q) != '0)
        |-> $past(reg_wr_i && (reg_addr_i == ADDR_W'(OFF_STAT))));

    // R5
    line_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) == (irq_o == '0));

    // R6
    prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_lvl == '0) == (stat_q[NUM_LEVELS-1:0] == '0));

    // R6
    prio_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_lvl != '0) |-> stat_q[top_lvl - 1'b1]);

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_id
        // R7
        id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(stat_q[i]) |-> $stable(id_q[i*REC_W +: REC_W]));
    end
endmodule

bind irq_level_collector irq_lc_chk #(
    .NUM_LEVELS  (NUM_LEVELS),
    .NUM_SPECIAL (NUM_SPECIAL),
    .NUM_LINES   (NUM_LINES),
    .ID_W        (ID_W),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .id_q       (id_q),
    .irq_o      (irq_o),
    .top_lvl    (top_lvl)
);

// File: tb/irq_level_collector_test.sv
`timescale 1ns/1ps
module irq_level_collector_test;
    import irq_lc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_valid_i = 1'b0;
    logic [2:0]  ack_level_i = '0;
    logic [7:0]  ack_id_i = '0;
    logic        ack_err_i = 1'b0;
    logic [7:0]  spec_pulse_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    logic [15:0] m_stat, m_en;
    logic [20:0] m_lmap;
    logic [23:0] m_smap;
    logic [8:0]  m_id [1:7];

    always #5 clk = ~clk;

    irq_level_collector uut (
        .clk(clk), .rst_n(rst_n),
        .ack_valid_i(ack_valid_i), .ack_level_i(ack_level_i),
        .ack_id_i(ack_id_i), .ack_err_i(ack_err_i),
        .spec_pulse_i(spec_pulse_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_lines();
        logic [7:0] l = '0;
        for (int n = 0; n < 7; n++)
            if (m_stat[n] && m_en[n]) l[m_lmap[3*n +: 3]] = 1'b1;
        for (int k = 0; k < 8; k++)
            if (m_stat[8+k] && m_en[8+k]) l[m_smap[3*k +: 3]] = 1'b1;
        return l;
    endfunction

    function automatic logic [31:0] exp_prio();
        logic [31:0] p = '0;
        for (int n = 1; n <= 7; n++)
            if (m_stat[n-1]) p = 32'(n);
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic check_all();
        logic [31:0] d;
        chk("R5 irq lines", {24'h0, irq_o}, {24'h0, exp_lines()});
        rd(8'h00, d); chk("R3 status", d, {16'h0, m_stat});
        rd(8'h04, d); chk("R4 enable", d, {16'h0, m_en});
        rd(8'h08, d); chk("R5 level map", d, {11'h0, m_lmap});
        rd(8'h0C, d); chk("R5 special map", d, {8'h0, m_smap});
        rd(8'h10, d); chk("R6 priority", d, exp_prio());
        for (int n = 1; n <= 7; n++) begin
            rd(8'(32'h20 + 4*(n-1)), d);
            chk("R7 id record", d, {23'h0, m_id[n]});
        end
    endtask

    // one clock with the given inputs; model advances alongside
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic av, input logic [2:0] al, input logic [7:0] aid,
                       input logic ae, input logic [7:0] sp);
        logic [15:0] clr, set, en_n;
        logic [20:0] lm_n;
        logic [23:0] sm_n;
        clr = (wr && a == 8'h00) ? (wd[15:0] & 16'hFF7F) : 16'h0;
        en_n = (wr && a == 8'h04) ? (wd[15:0] & 16'hFF7F) : m_en;
        lm_n = (wr && a == 8'h08) ? wd[20:0] : m_lmap;
        sm_n = (wr && a == 8'h0C) ? wd[23:0] : m_smap;
        set = '0;
        if (av && al != 3'd0 && m_en[al-1] && !m_stat[al-1]) begin
            set[al-1] = 1'b1;
            m_id[al] = {ae, aid};
        end
        set[15:8] = sp & m_en[15:8];
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
        ack_valid_i = av; ack_level_i = al; ack_id_i = aid; ack_err_i = ae;
        spec_pulse_i = sp;
        @(posedge clk);
        #1;
        reg_wr_i = 1'b0; ack_valid_i = 1'b0; spec_pulse_i = '0;
        m_stat = (m_stat & ~clr) | set;
        m_en = en_n; m_lmap = lm_n; m_smap = sm_n;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 3'd0, 8'h0, 1'b0, 8'h0);
    endtask

    task automatic ack(input logic [2:0] l, input logic [7:0] id, input logic e);
        cyc(1'b0, 8'h0, 32'h0, 1'b1, l, id, e, 8'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed_dummy;
        m_stat = '0; m_en = '0; m_lmap = '0; m_smap = '0;
        for (int n = 1; n <= 7; n++) m_id[n] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R8 reset state
        check_all();
        rd(8'h14, d); chk("R8 unmapped 0x14", d, 32'h0);
        rd(8'h3C, d); chk("R8 unmapped 0x3C", d, 32'h0);

        // R1 disabled level refuses acknowledge
        ack(3'd3, 8'h5A, 1'b0);
        check_all();
        // route level 3 to line 5, enable it, acknowledge
        wr(8'h08, 32'(5) << 6);
        wr(8'h04, 32'h0000_0004);
        ack(3'd3, 8'hA5, 1'b0);
        chk("R1 level3 accepted irq", {24'h0, irq_o}, 32'h20);
        check_all();
        // R7 second acknowledge while pending ignored
        ack(3'd3, 8'h11, 1'b1);
        rd(8'h28, d); chk("R7 id held while pending", d, 32'h0A5);
        // R1 level 0 ignored
        ack(3'd0, 8'h77, 1'b0);
        check_all();
        // R4 mask keeps status
        wr(8'h04, 32'h0);
        chk("R4 masked line low", {24'h0, irq_o}, 32'h0);
        rd(8'h00, d); chk("R4 status kept", d, 32'h4);
        rd(8'h10, d); chk("R6 prio ignores enable", d, 32'h3);
        // R7 level 7 with error, priority
        wr(8'h04, 32'h0000_0040);
        ack(3'd7, 8'hC3, 1'b1);
        rd(8'h38, d); chk("R7 error flag", d, 32'h1C3);
        rd(8'h10, d); chk("R6 prio level7", d, 32'h7);
        // R3 write zeros no effect, then clear level 7
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R3 zero write", d, 32'h44);
        wr(8'h00, 32'h40);
        rd(8'h00, d); chk("R3 clear level7", d, 32'h4);
        rd(8'h10, d); chk("R6 prio back to 3", d, 32'h3);
        // R2 special source: DMA done to line 0, disabled pulse ignored
        cyc(1'b0, 8'h0, 32'h0, 1'b0, 3'd0, 8'h0, 1'b0, 8'h01 << SP_DMA_DONE);
        rd(8'h00, d); chk("R2 disabled pulse ignored", d, 32'h4);
        wr(8'h04, 32'h1 << (8 + SP_DMA_DONE));
        cyc(1'b0, 8'h0, 32'h0, 1'b0, 3'd0, 8'h0, 1'b0, 8'h01 << SP_DMA_DONE);
        chk("R2 dma line 0", {24'h0, irq_o}, 32'h01);
        // R3 clear and set same cycle: set wins
        cyc(1'b1, 8'h00, 32'h1 << (8 + SP_DMA_DONE), 1'b0, 3'd0, 8'h0, 1'b0,
            8'h01 << SP_DMA_DONE);
        rd(8'h00, d); chk("R3 set beats clear", d, 32'h404);
        check_all();

        // random phase
        seed_dummy = $urandom(32'h1CE5);
        for (int it = 0; it < 3000; it++) begin
            logic w;
            logic [7:0] a;
            logic [31:0] wd;
            int unsigned op;
            op = $urandom % 4;
            a = (op == 0) ? 8'h00 : (op == 1) ? 8'h04 : (op == 2) ? 8'h08 : 8'h0C;
            w = ($urandom % 3) == 0;
            wd = $urandom;
            cyc(w, a, wd, ($urandom % 2) == 1, 3'($urandom), 8'($urandom),
                1'($urandom), 8'($urandom) & 8'($urandom));
            check_all();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule